// File: doc/BRIEF.md
# Event Counter Bank with Wrap Interrupt

The block is a performance-monitoring unit that holds eight event counters behind a simple 32-bit register bus. Each counter picks one of 256 single-cycle event pulses through an 8-bit select code. The code 0x7F counts every clock instead. A counter advances only while its own enable bit and one shared enable bit are both set. Software can read and load every counter as two 32-bit words.

A counter that rolls over from all-ones to zero latches a per-counter status flag. The flags that a mask register leaves open are ORed into one registered interrupt line. Software acknowledges a flag by writing a one to its bit in a separate clear register. Counter width is a parameter: in the 48-bit build the upper sixteen bits of the high word read as zero and drop writes. A read-only identifier register reports a version code.

The bus has no handshake. A write lands on the rising edge where `bus_wr` is high. Read data follows `bus_addr` combinationally.

Top module: `evcnt_bank`

## Requirements
- R1: After reset all counters, enables, select codes and status flags are zero, the mask register (offset 0x0800) reads 0xFF (all masked) and `irq_o` is low.
- R2: Bit 16 of the control register at offset 0x0408 is the shared enable; while it is clear no counter changes except by a software write.
- R3: Bit n of the enable register at offset 0x1C00 lets counter n count; a counter whose bit is clear ignores its events.
- R4: Select codes are packed four per word: counters 0-3 at offset 0x1D00 and counters 4-7 at 0x1D04, counter n in bits [8*(n%4)+7 : 8*(n%4)]; an enabled counter adds one on each clock where `evt_i[code]` is high.
- R5: Select code 0x7F adds one on every clock while the counter is enabled, regardless of `evt_i`.
- R6: Counter n's low word sits at offset 0x1E00+8*n and its high word at 0x1E04+8*n; both are readable and writable, and a write takes priority over an increment on the same edge.
- R7: With CNT_W=48 the high word's bits [31:16] read as zero and writes to them are dropped.
- R8: When counter n rolls over from all-ones to zero, status bit n (offset 0x0808) is set on that same edge; the status register ignores writes, and a set beats a clear on the same edge.
- R9: Writing a one to bit n of the clear register at offset 0x080C clears status bit n; zero bits leave flags unchanged.
- R10: `irq_o` is high one clock after any status bit whose mask bit is 0 is set, and goes low one clock after no such bit remains; mask bit 1 blocks the flag.
- R11: Offset 0x1CF0 returns the VERSION parameter and ignores writes; unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per high clock |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_i | input | 2**SEL_W | Event pulses, indexed by select code |
| irq_o | output | 1 | Registered interrupt, active high |

## Verification
The timing rules below set when each check samples:

- **Counter, status and register writes.** These results are due on the first rising edge after the stimulus is presented at a falling edge. The bench reads them back at the following falling edge, because the read path has no register.
- **Interrupt line.** `irq_o` lags the status flags and the mask by one more edge. The bench checks it twice: once at the falling edge just after the causing edge, where it must still hold its old value, and again one cycle later.
- **Cycle counting.** The expected value counts every edge from the load up to and including the edge that disables the counter. The enable is still set on that final edge, so it counts.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  // Register byte offsets
  localparam int unsigned OFS_CTRL   = 32'h0408;
  localparam int unsigned OFS_MASK   = 32'h0800;
  localparam int unsigned OFS_STAT   = 32'h0808;
  localparam int unsigned OFS_CLR    = 32'h080C;
  localparam int unsigned OFS_EN     = 32'h1C00;
  localparam int unsigned OFS_VER    = 32'h1CF0;
  localparam int unsigned OFS_SEL    = 32'h1D00;
  localparam int unsigned OFS_CNT    = 32'h1E00;
  // Bit position of the shared enable within the control word
  localparam int unsigned GLB_EN_BIT = 16;
  // Select code that counts every clock
  localparam int unsigned CYCLE_CODE = 32'h7F;
  // Codes packed per select word
  localparam int unsigned CODES_PER_WORD = 4;
endpackage

// File: rtl/evcnt_cfg_regs.sv
module evcnt_cfg_regs
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int SEL_W   = 8,
  parameter int ADDR_W  = 13
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [31:0]                    wdata_i,
  output logic                           glob_en_o,
  output logic [NUM_CNT-1:0]             cnt_en_o,
  output logic [NUM_CNT-1:0]             mask_o,
  output logic [NUM_CNT-1:0][SEL_W-1:0]  sel_o
);
  logic                          glob_q, glob_d;
  logic [NUM_CNT-1:0]            en_q, en_d;
  logic [NUM_CNT-1:0]            mask_q, mask_d;
  logic [NUM_CNT-1:0][SEL_W-1:0] sel_q, sel_d;
  logic                          ld_ctrl, ld_en, ld_mask;
  logic [NUM_CNT-1:0]            ld_sel;

  always_comb begin
    ld_ctrl = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
    ld_en   = wr_i && (addr_i == ADDR_W'(OFS_EN));
    ld_mask = wr_i && (addr_i == ADDR_W'(OFS_MASK));
    glob_d  = wdata_i[GLB_EN_BIT];
    en_d    = wdata_i[NUM_CNT-1:0];
    mask_d  = wdata_i[NUM_CNT-1:0];
    for (int n = 0; n < NUM_CNT; n++) begin
      ld_sel[n] = wr_i &&
        (addr_i == ADDR_W'(OFS_SEL + 4 * (n / CODES_PER_WORD)));
      sel_d[n]  = wdata_i[8 * (n % CODES_PER_WORD) +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= 1'b0;
      en_q   <= '0;
      mask_q <= '1;
      sel_q  <= '0;
    end else begin
      if (ld_ctrl) glob_q <= glob_d;
      if (ld_en)   en_q   <= en_d;
      if (ld_mask) mask_q <= mask_d;
      for (int n = 0; n < NUM_CNT; n++)
        if (ld_sel[n]) sel_q[n] <= sel_d[n];
    end
  end

  assign glob_en_o = glob_q;
  assign cnt_en_o  = en_q;
  assign mask_o    = mask_q;
  assign sel_o     = sel_q;

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == ADDR_W'(OFS_EN)) |=> $stable(en_q));
endmodule

// File: rtl/evcnt_counter.sv
module evcnt_counter
  import evcnt_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int SEL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glob_en_i,
  input  logic                  en_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [(1<<SEL_W)-1:0] evt_i,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic [31:0]           wdata_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  wrap_o
);
  localparam int HI_W = CNT_W - 32;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit, inc, load_en;

  always_comb begin
    hit     = (sel_i == SEL_W'(CYCLE_CODE)) ? 1'b1 : evt_i[sel_i];
    inc     = glob_en_i && en_i && hit;
    load_en = wr_lo_i || wr_hi_i || inc;
    cnt_d   = cnt_q;
    wrap_o  = 1'b0;
    if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_d[31:0]      = wdata_i;
      if (wr_hi_i) cnt_d[CNT_W-1:32] = wdata_i[HI_W-1:0];
    end else if (inc) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_o = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2
  glob_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
  // R6
  sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> cnt_q[31:0] == $past(wdata_i));
endmodule

// File: rtl/evcnt_irq_ctl.sv
module evcnt_irq_ctl #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] wrap_i,
  input  logic               clr_wr_i,
  input  logic [NUM_CNT-1:0] clr_bits_i,
  input  logic [NUM_CNT-1:0] mask_i,
  output logic [NUM_CNT-1:0] status_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0] status_q, status_d, clr_vec;
  logic               irq_q, irq_d;

  always_comb begin
    clr_vec  = clr_wr_i ? clr_bits_i : '0;
    status_d = (status_q & ~clr_vec) | wrap_i;
    irq_d    = |(status_q & ~mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= irq_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R8
  wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_i) |=> ((status_q & $past(wrap_i)) == $past(wrap_i)));
  // R9
  clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && wrap_i == '0) |=> ((status_q & $past(clr_bits_i)) == '0));
  // R10
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_i) |=> !irq_o);
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
  import evcnt_pkg::*;
#(
  parameter int          NUM_CNT = 8,
  parameter int          CNT_W   = 48,
  parameter int          SEL_W   = 8,
  parameter int          ADDR_W  = 13,
  parameter logic [31:0] VERSION = 32'h0003_0100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [(1<<SEL_W)-1:0] evt_i,
  output logic                  irq_o
);
  localparam int NUM_SEL_WORDS = (NUM_CNT + CODES_PER_WORD - 1) / CODES_PER_WORD;

  logic [1:0]                    rst_sync;
  logic                          rst_n_s;
  logic                          glob_en;
  logic [NUM_CNT-1:0]            cnt_en, mask, status, wrap, wr_lo, wr_hi;
  logic [NUM_CNT-1:0][SEL_W-1:0] sel;
  logic [CNT_W-1:0]              cnt [NUM_CNT];
  logic                          clr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  evcnt_cfg_regs #(.NUM_CNT(NUM_CNT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .glob_en_o(glob_en), .cnt_en_o(cnt_en),
    .mask_o(mask), .sel_o(sel)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    assign wr_lo[n] = bus_wr && (bus_addr == ADDR_W'(OFS_CNT + 8 * n));
    assign wr_hi[n] = bus_wr && (bus_addr == ADDR_W'(OFS_CNT + 8 * n + 4));
    evcnt_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctr (
      .clk(clk), .rst_n(rst_n_s), .glob_en_i(glob_en), .en_i(cnt_en[n]),
      .sel_i(sel[n]), .evt_i(evt_i), .wr_lo_i(wr_lo[n]), .wr_hi_i(wr_hi[n]),
      .wdata_i(bus_wdata), .cnt_o(cnt[n]), .wrap_o(wrap[n])
    );
  end

  assign clr_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CLR));

  evcnt_irq_ctl #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk(clk), .rst_n(rst_n_s), .wrap_i(wrap), .clr_wr_i(clr_wr),
    .clr_bits_i(bus_wdata[NUM_CNT-1:0]), .mask_i(mask),
    .status_o(status), .irq_o(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata[GLB_EN_BIT] = glob_en;
    if (bus_addr == ADDR_W'(OFS_EN))   bus_rdata = 32'(cnt_en);
    if (bus_addr == ADDR_W'(OFS_MASK)) bus_rdata = 32'(mask);
    if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = 32'(status);
    if (bus_addr == ADDR_W'(OFS_VER))  bus_rdata = VERSION;
    for (int w = 0; w < NUM_SEL_WORDS; w++)
      if (bus_addr == ADDR_W'(OFS_SEL + 4 * w))
        for (int k = 0; k < CODES_PER_WORD; k++)
          if (w * CODES_PER_WORD + k < NUM_CNT)
            bus_rdata[8 * k +: SEL_W] = sel[w * CODES_PER_WORD + k];
    for (int n = 0; n < NUM_CNT; n++) begin
      if (bus_addr == ADDR_W'(OFS_CNT + 8 * n))     bus_rdata = cnt[n][31:0];
      if (bus_addr == ADDR_W'(OFS_CNT + 8 * n + 4)) bus_rdata = 32'(cnt[n][CNT_W-1:32]);
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n_s |=> !irq_o);
endmodule

// File: tb/sim_evcnt_bank.sv
module sim_evcnt_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [12:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [255:0] evt;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [31:0] VER = 32'h0003_0100;

  always #2.5 clk = ~clk;

  evcnt_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; write lands at the next rising edge.
  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input int code);
    evt[code] = 1'b1;
    @(posedge clk); @(negedge clk);
    evt[code] = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(13'h1E00, v); check("R1 cnt0", v, 0);
    rd(13'h0800, v); check("R1 mask", v, 32'hFF);
    rd(13'h0808, v); check("R1 status", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    // R11 version and unmapped
    rd(13'h1CF0, v); check("R11 version", v, VER);
    rd(13'h0004, v); check("R11 unmapped", v, 0);

    // R4 select packing
    wr(13'h1D00, 32'h13121110);
    wr(13'h1D04, 32'h17161514);
    rd(13'h1D04, v); check("R4 sel word1", v, 32'h17161514);
    // R2 shared enable clear: nothing counts
    wr(13'h1C00, 32'hFF);
    for (int n = 0; n < 8; n++) pulse(16 + n);
    for (int n = 0; n < 8; n++) begin
      rd(13'(32'h1E00 + 8 * n), v); check("R2 gated", v, 0);
    end

    // R3/R4 per-counter enable and event routing
    wr(13'h1C00, 32'h55);
    wr(13'h0408, 32'h0001_0000);
    rd(13'h0408, v); check("R2 ctrl read", v, 32'h0001_0000);
    for (int n = 0; n < 8; n++)
      for (int k = 0; k <= n; k++) pulse(16 + n);
    for (int n = 0; n < 8; n++) begin
      rd(13'(32'h1E00 + 8 * n), v);
      check((n % 2 == 0) ? "R4 routed count" : "R3 disabled counter", v,
            (n % 2 == 0) ? 32'(n + 1) : 0);
    end

    // R5 cycle code on counter 7
    wr(13'h1D04, 32'h7F161514);
    wr(13'h1C00, 32'h80);
    wr(13'h1E38, 32'h0);
    repeat (37) @(negedge clk);
    wr(13'h1C00, 32'h00);
    rd(13'h1E38, v); check("R5 cycle count", v, 38);

    // R6 write beats increment
    wr(13'h1C00, 32'h80);
    wr(13'h1E38, 32'h1234);
    rd(13'h1E38, v); check("R6 write wins", v, 32'h1234);
    @(negedge clk);
    rd(13'h1E38, v); check("R6 counts on", v, 32'h1235);
    wr(13'h1C00, 32'h00);

    // R7 48-bit high word
    wr(13'h1E04, 32'hFFFF_FFFF);
    rd(13'h1E04, v); check("R7 high bits zero", v, 32'h0000_FFFF);
    rd(13'h1E00, v); check("R6 low untouched", v, 1);

    // R8/R10 wrap of counter 1
    wr(13'h1E08, 32'hFFFF_FFFF);
    wr(13'h1E0C, 32'h0000_FFFF);
    wr(13'h0800, 32'hFD);
    wr(13'h1C00, 32'h02);
    pulse(17);
    rd(13'h0808, v); check("R8 status set", v, 32'h02);
    check("R10 irq lags", {31'b0, irq}, 0);
    @(negedge clk);
    check("R10 irq up", {31'b0, irq}, 1);
    rd(13'h1E08, v); check("R8 low wrapped", v, 0);
    rd(13'h1E0C, v); check("R8 high wrapped", v, 0);
    wr(13'h0808, 32'h0);
    rd(13'h0808, v); check("R8 status ignores write", v, 32'h02);

    // R10 masking
    wr(13'h0800, 32'hFF);
    check("R10 mask lag", {31'b0, irq}, 1);
    @(negedge clk);
    check("R10 masked", {31'b0, irq}, 0);
    wr(13'h0800, 32'hFD);
    check("R10 unmask lag", {31'b0, irq}, 0);
    @(negedge clk);
    check("R10 unmasked", {31'b0, irq}, 1);

    // R9 clear
    wr(13'h080C, 32'h02);
    rd(13'h0808, v); check("R9 cleared", v, 0);
    @(negedge clk);
    check("R9 irq drops", {31'b0, irq}, 0);

    // R8 set beats clear on the same edge
    wr(13'h1E08, 32'hFFFF_FFFF);
    wr(13'h1E0C, 32'h0000_FFFF);
    evt[17] = 1'b1; bus_wr = 1'b1; bus_addr = 13'h080C; bus_wdata = 32'h02;
    @(posedge clk); @(negedge clk);
    evt[17] = 1'b0; bus_wr = 1'b0;
    rd(13'h0808, v); check("R8 set beats clear", v, 32'h02);

    // R9 zero bits leave flags
    wr(13'h080C, 32'h01);
    rd(13'h0808, v); check("R9 other bit kept", v, 32'h02);
    wr(13'h080C, 32'h02);
    rd(13'h0808, v); check("R9 final clear", v, 0);

    // R11 version ignores writes
    wr(13'h1CF0, 32'h0);
    rd(13'h1CF0, v); check("R11 version read-only", v, VER);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule